// File: doc/BRIEF.md
# AES Encryption Byte-Step Unit

This functional unit serves a 32-bit processor core and executes the two scalar AES encryption steps. Each operation takes one byte of the second source word, chosen by a 2-bit lane index, and substitutes it through the forward AES S-box. The substituted byte is then either kept as a single byte (final-round step) or expanded into a one-byte MixColumns contribution (middle-round step). The resulting word is rotated so that it lines up with the chosen lane and is XORed into the first source word.

Software builds one 32-bit column of an AES round by issuing four operations, one per lane, with each result fed back as the first operand of the next. The unit computes the S-box arithmetically: it takes the GF(2^8) inverse and then applies the affine map. The result is registered, has a single cycle of latency and accepts no back-pressure.

Top module: `aes_enc_step`

## Requirements
- R1: The input byte is `src2[8*byte_sel+7 : 8*byte_sel]` and the rotate amount is `8*byte_sel`, for every byte_sel value 0 to 3.
- R2: The substitution is the forward AES S-box (GF(2^8) inverse modulo 0x11B, with 0 mapping to 0, followed by the affine map with constant 0x63). For example, 0x00 gives 0x63 and 0x53 gives 0xED.
- R3: With `mix_en`=0 (final-round step), the result is `src1` XOR (S-box output zero-extended to 32 bits and rotated left by `8*byte_sel`). The three other bytes of `src1` pass through unchanged.
- R4: With `mix_en`=1 (middle-round step), the S-box output s is expanded to a word with byte 0 = 2·s, bytes 1 and 2 = s and byte 3 = 3·s, using GF(2^8) products modulo 0x11B. This word is rotated left by `8*byte_sel` and XORed into `src1`.
- R5: `mix_en` selects between the two steps per operation. Back-to-back operations that alternate between them each produce their own step's result.
- R6: `out_valid` is high in exactly the cycle after an edge with `in_valid` high, and `result` holds that operation's value in the same cycle.
- R7: While `in_valid` is low, `result` keeps its last value and the operand inputs have no effect.
- R8: A synchronous active-low `rst_n` clears `out_valid` and `result` to 0.
- R9: Four final-round operations on lanes 0 to 3 that start from `src1`=0 and feed each result back as `src1` produce the byte-wise S-box of `src2`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| mix_en | input | 1 | 1 = middle-round step, 0 = final-round step |
| byte_sel | input | 2 | Lane index of the selected byte |
| src1 | input | 32 | Accumulator operand |
| src2 | input | 32 | Operand holding the byte to substitute |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Registered result |

## Verification
Two fixed S-box points are checked: zero, and a byte that sets the top bit of the S-box output. The second exercises the xtime reduction by 0x1B. The bench then sweeps every lane with both steps over random operands. This separates lane-extraction faults from rotation faults, because the byte read and the byte written only move together when both are correct. Alternating the step on consecutive operations separates a per-operation step select from a stale one. A four-lane accumulation chain shows that bytes outside the selected lane pass through from `src1`. Idle cycles with changing operands, and a reset that lands after an operation, test the hold and clear behaviour.

// File: rtl/aes_enc_step.sv
module aes_enc_step #(
  parameter int unsigned WORD_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic                         mix_en,
  input  logic [$clog2(WORD_W/8)-1:0]  byte_sel,
  input  logic [WORD_W-1:0]            src1,
  input  logic [WORD_W-1:0]            src2,
  output logic                         out_valid,
  output logic [WORD_W-1:0]            result
);
  localparam int unsigned SEL_W = $clog2(WORD_W/8);
  localparam int unsigned SH_W  = SEL_W + 3;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, t;
    p = 8'h00;
    t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ t;
      t = xtime(t);
    end
    return p;
  endfunction

  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] r, q;
    r = 8'h01;
    q = x;
    for (int i = 1; i < 8; i++) begin
      q = gf_mul(q, q);
      r = gf_mul(r, q);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotb(input logic [7:0] b, input int k);
    return (b << k) | (b >> (8 - k));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] v;
    v = gf_inv(x);
    return v ^ rotb(v, 1) ^ rotb(v, 2) ^ rotb(v, 3) ^ rotb(v, 4) ^ 8'h63;
  endfunction

  logic [SH_W-1:0]     shamt;
  logic [7:0]          in_byte, sub_byte, dbl_byte;
  logic [WORD_W-1:0]   spread;
  logic [2*WORD_W-1:0] rot_dbl;

  assign shamt    = {byte_sel, 3'b000};
  assign in_byte  = src2[shamt +: 8];
  assign sub_byte = sbox(in_byte);
  assign dbl_byte = xtime(sub_byte);

  always_comb begin
    spread = '0;
    if (mix_en) begin
      spread[7:0]   = dbl_byte;
      spread[15:8]  = sub_byte;
      spread[23:16] = sub_byte;
      spread[31:24] = dbl_byte ^ sub_byte;
    end else begin
      spread[7:0]   = sub_byte;
    end
  end

  assign rot_dbl = {spread, spread} << shamt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= src1 ^ rot_dbl[2*WORD_W-1:WORD_W];
    end
  end
endmodule

module aes_enc_step_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        mix_en,
  input logic [1:0]  byte_sel,
  input logic [31:0] src1,
  input logic [31:0] src2,
  input logic        out_valid,
  input logic [31:0] result
);
  function automatic logic [7:0] lane(input logic [31:0] w, input logic [1:0] i);
    return w[{i, 3'b000} +: 8];
  endfunction

  // R8
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && result == 32'h0));

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  // R3
  final_lane_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mix_en) |=>
      ((result ^ $past(src1)) & ~(32'hff << {$past(byte_sel), 3'b000})) == 32'h0);

  // R4
  mid_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mix_en) |=>
      lane(result ^ $past(src1), $past(byte_sel) + 2'd1) ==
      lane(result ^ $past(src1), $past(byte_sel) + 2'd2));
endmodule

bind aes_enc_step aes_enc_step_chk chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mix_en(mix_en),
  .byte_sel(byte_sel), .src1(src1), .src2(src2),
  .out_valid(out_valid), .result(result)
);

// File: tb/aes_enc_step_test.sv
module aes_enc_step_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        mix_en = 1'b0;
  logic [1:0]  byte_sel = 2'd0;
  logic [31:0] src1 = '0, src2 = '0;
  logic        out_valid;
  logic [31:0] result;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  aes_enc_step uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mix_en(mix_en),
    .byte_sel(byte_sel), .src1(src1), .src2(src2),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] acc = '0;
    for (int i = 0; i < 8; i++) if (b[i]) acc ^= (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (acc[i]) acc ^= (16'h11b << (i - 8));
    return acc[7:0];
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] x);
    logic [7:0] inv = 8'h00, s;
    logic [7:0] c = 8'h63;
    for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
    return s;
  endfunction

  function automatic logic [31:0] m_step(input logic mix, input logic [1:0] sel,
                                         input logic [31:0] a, input logic [31:0] b);
    logic [7:0]  s = m_sbox(b[sel*8 +: 8]);
    logic [31:0] w, r;
    w = mix ? {m_mul(s, 8'h03), s, s, m_mul(s, 8'h02)} : {24'h0, s};
    r = w;
    for (int k = 0; k < int'(sel); k++) r = {r[23:0], r[31:24]};
    return a ^ r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic mix, input logic [1:0] sel,
                       input logic [31:0] a, input logic [31:0] b, output logic [31:0] r);
    @(negedge clk);
    in_valid = 1'b1; mix_en = mix; byte_sel = sel; src1 = a; src2 = b;
    @(negedge clk);
    in_valid = 1'b0;
    r = result;
    checks++;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R6 out_valid actual=%b expected=1", out_valid);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R8 reset out_valid", 32'(out_valid), 32'h0);
    check("R8 reset result", result, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_known();
    logic [31:0] r;
    issue(1'b0, 2'd0, 32'h0, 32'h0, r);
    check("R2 sbox 00", r, 32'h00000063);
    issue(1'b0, 2'd2, 32'h0, 32'h00530000, r);
    check("R2 sbox 53", r, 32'h00ED0000);
    issue(1'b1, 2'd0, 32'h0, 32'h0, r);
    check("R4 mid s=63", r, 32'hA56363C6);
    issue(1'b1, 2'd1, 32'h0, 32'h00005300, r);
    check("R4 mid s=ED", r, 32'hEDEDC12C);
  endtask

  task automatic t_lanes();
    logic [31:0] r, a, b;
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int n = 0; n < 16; n++) begin
          a = $urandom; b = $urandom;
          issue(m[0], 2'(s), a, b, r);
          check(m ? "R1 R4 mid lane" : "R1 R3 final lane", r, m_step(m[0], 2'(s), a, b));
        end
  endtask

  task automatic t_alternate();
    logic [31:0] a, b;
    @(negedge clk);
    for (int n = 0; n < 12; n++) begin
      a = $urandom; b = $urandom;
      in_valid = 1'b1; mix_en = n[0]; byte_sel = 2'(n); src1 = a; src2 = b;
      @(negedge clk);
      check("R5 alternate step", result, m_step(n[0], 2'(n), a, b));
      check("R6 back-to-back valid", 32'(out_valid), 32'h1);
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R6 valid drops", 32'(out_valid), 32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] r;
    issue(1'b1, 2'd3, 32'h12345678, 32'h9abcdef0, r);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      src1 = $urandom; src2 = $urandom; mix_en = n[0]; byte_sel = 2'(n);
    end
    @(negedge clk);
    check("R7 hold result", result, r);
    check("R7 idle out_valid", 32'(out_valid), 32'h0);
  endtask

  task automatic t_chain();
    logic [31:0] acc = 32'h0;
    logic [31:0] b = 32'hC3A5_0F81;
    for (int s = 0; s < 4; s++) issue(1'b0, 2'(s), acc, b, acc);
    check("R9 column chain", acc,
          {m_sbox(b[31:24]), m_sbox(b[23:16]), m_sbox(b[15:8]), m_sbox(b[7:0])});
  endtask

  task automatic t_reset_late();
    logic [31:0] r;
    issue(1'b1, 2'd2, 32'hffff0000, 32'h00ab0000, r);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    check("R8 reset clears result", result, 32'h0);
    check("R8 reset clears valid", 32'(out_valid), 32'h0);
    in_valid = 1'b0;
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd7));
    t_reset();
    t_known();
    t_lanes();
    t_alternate();
    t_hold();
    t_chain();
    t_reset_late();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule